// File: doc/BRIEF.md
# Pointer-Indexed Control Port Access Unit

This unit sits between a simple host bus and a peripheral whose many 8-bit internal registers all share one control address. The host reaches any internal register in two phases. It first writes the register number to the control address. It then writes or reads that register through the same address. A two-state machine records which phase the next control-port write belongs to. Three further host addresses give direct access to the peripheral's data ports. These accesses bypass the pointer entirely.

The unit decodes the 2-bit host address. It drives the internal register select, a write strobe, a read strobe and the read-data multiplexer. The internal registers belong to neighbouring blocks, with one exception: register 0, whose bit 0 is a device-reset control held inside this unit. While that bit is set, the peripheral is held in reset. The unit then accepts only writes that go to register 0. A fixed six-access recovery sequence brings the unit back to the pointer phase from any state, and it pulses the device reset on the way.

Top module: `regptr_host_if`

## Requirements
- R1: The host address selects the target. Address 0 is port C, 1 is port B, 2 is port A and 3 is the control port. A read at address 0, 1 or 2 returns `port_c_in`, `port_b_in` or `port_a_in` in the same cycle. A write there pulses `port_we[addr]` for that cycle.
- R2: In the pointer phase, a control-port write latches the low `PTR_W` bits of the data as the register number on `reg_sel`, from the next cycle on. It moves the unit to the data phase and raises no `reg_wr`.
- R3: In the data phase, a control-port write to a register other than 0 pulses `reg_wr` in the same cycle, with `reg_sel` holding the latched number and `reg_wdata` carrying the value. The unit then returns to the pointer phase.
- R4: A control-port read returns the latched register in the same cycle. For a nonzero register this is `reg_rdata`, and `reg_rd` pulses. For register 0 it is the reset bit in bit 0, with all other bits zero.
- R5: Any control-port read returns the unit to the pointer phase, even when no pointer was written first.
- R6: The reset bit is bit 0 of register 0. A data-phase write of 1 to register 0 sets `dev_reset`, and a write of 0 clears it. After `rst_n`, `dev_reset` is 1, the pointer is 0 and the unit is in the pointer phase.
- R7: While `dev_reset` is 1, `reg_wr` and `port_we` stay low and the unit stays in the pointer phase. Each control-port write loads its bit 0 straight into the reset bit and leaves the pointer unchanged.
- R8: A write to address 0, 1 or 2 never changes the phase or the latched pointer.
- R9: The sequence read control, write 0, read control, write 0, write 1, write 0 works from any state. It sets `dev_reset` after the fifth access and clears it after the sixth, and it leaves the unit in the pointer phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_addr | input | 2 | Host address (0..2 direct ports, 3 control port) |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Host read data, combinational |
| port_c_in | input | DATA_W | Port C read value (address 0) |
| port_b_in | input | DATA_W | Port B read value (address 1) |
| port_a_in | input | DATA_W | Port A read value (address 2) |
| port_we | output | 3 | Direct port write strobes, bit index equals address |
| reg_sel | output | PTR_W | Latched internal register number |
| reg_wr | output | 1 | Internal register write strobe |
| reg_rd | output | 1 | Internal register read strobe |
| reg_wdata | output | DATA_W | Internal register write data |
| reg_rdata | input | DATA_W | Data of the selected internal register |
| dev_reset | output | 1 | Device reset control (register 0, bit 0) |

## Verification
The embedded properties check several rules on every cycle:
- a pointer write leads to the data phase with the written number latched;
- a read forces the pointer phase;
- a direct-port write leaves the phase and the pointer untouched;
- while reset is held, no write strobe leaves the unit and the phase stays at pointer.

Other behaviours only the bench's scenarios can show, because they depend on a whole access history rather than one step. These are the alternation of pointer and data over long runs, the value a read returns for each register, and the recovery sequence working both from the data phase and from the reset-held state.

// File: rtl/regptr_host_if.sv
module regptr_host_if #(
  parameter int DATA_W = 8,
  parameter int PTR_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        host_addr,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  input  logic [DATA_W-1:0] port_c_in,
  input  logic [DATA_W-1:0] port_b_in,
  input  logic [DATA_W-1:0] port_a_in,
  output logic [2:0]        port_we,
  output logic [PTR_W-1:0]  reg_sel,
  output logic              reg_wr,
  output logic              reg_rd,
  output logic [DATA_W-1:0] reg_wdata,
  input  logic [DATA_W-1:0] reg_rdata,
  output logic              dev_reset
);
  localparam logic [1:0] CTRL_ADDR = 2'd3;

  logic             data_ph;
  logic [PTR_W-1:0] ptr;
  logic             rst_bit;

  wire ctrl_wr  = host_wr && host_addr == CTRL_ADDR;
  wire ctrl_rd  = host_rd && !host_wr && host_addr == CTRL_ADDR;
  wire ptr_zero = ptr == '0;

  assign reg_sel   = ptr;
  assign reg_wdata = host_wdata;
  assign dev_reset = rst_bit;
  assign reg_wr    = ctrl_wr && data_ph && !rst_bit && !ptr_zero;
  assign reg_rd    = ctrl_rd && !ptr_zero;

  for (genvar i = 0; i < 3; i++) begin : g_port_we
    assign port_we[i] = host_wr && !rst_bit && host_addr == 2'(i);
  end

  wire [DATA_W-1:0] ctrl_rdata = ptr_zero ? DATA_W'(rst_bit) : reg_rdata;

  always_comb begin
    case (host_addr)
      2'd0:    host_rdata = port_c_in;
      2'd1:    host_rdata = port_b_in;
      2'd2:    host_rdata = port_a_in;
      default: host_rdata = ctrl_rdata;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_ph <= 1'b0;
      ptr     <= '0;
      rst_bit <= 1'b1;
    end else if (rst_bit) begin
      data_ph <= 1'b0;
      if (ctrl_wr) rst_bit <= host_wdata[0];
    end else if (ctrl_wr) begin
      if (!data_ph) begin
        ptr     <= host_wdata[PTR_W-1:0];
        data_ph <= 1'b1;
      end else begin
        data_ph <= 1'b0;
        if (ptr_zero) rst_bit <= host_wdata[0];
      end
    end else if (ctrl_rd) begin
      data_ph <= 1'b0;
    end
  end

  p_ptr_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !data_ph && !rst_bit) |=> (data_ph && reg_sel == $past(host_wdata[PTR_W-1:0])));

  p_read_resync_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_rd |=> !data_ph);

  p_rst_holds_ptr_phase_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dev_reset |-> (!data_ph && !reg_wr && port_we == 3'b000));

  p_port_keeps_state_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr != CTRL_ADDR) |=> ($stable(data_ph) && $stable(reg_sel)));

  p_rst_write_keeps_ptr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_reset && ctrl_wr) |=> $stable(reg_sel));
endmodule

// File: tb/regptr_host_if_test.sv
module regptr_host_if_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] host_addr = '0;
  logic       host_wr = 1'b0, host_rd = 1'b0;
  logic [7:0] host_wdata = '0, host_rdata;
  logic [2:0] port_we;
  logic [5:0] reg_sel;
  logic       reg_wr, reg_rd, dev_reset;
  logic [7:0] reg_wdata, reg_rdata;
  int applied = 0, bad = 0;

  always #4 clk = ~clk;

  assign reg_rdata = 8'h80 | {2'b00, reg_sel};

  regptr_host_if uut (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .port_c_in(8'h3C), .port_b_in(8'hB1), .port_a_in(8'hA2),
    .port_we(port_we), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dev_reset(dev_reset));

  localparam int NV = 28;
  // {op(1=wr,2=rd), addr, wdata, exp reg_wr, exp reg_sel, exp rdata, exp port_we, exp dev_reset after edge}
  localparam logic [30:0] VEC [NV] = '{
    {2'd1,2'd3,8'h00,1'b0,6'h00,8'h00,3'b000,1'b0}, // R7 release
    {2'd1,2'd0,8'h55,1'b0,6'h00,8'h00,3'b001,1'b0}, // R1
    {2'd1,2'd1,8'h66,1'b0,6'h00,8'h00,3'b010,1'b0}, // R1
    {2'd1,2'd2,8'h77,1'b0,6'h00,8'h00,3'b100,1'b0}, // R1
    {2'd2,2'd0,8'h00,1'b0,6'h00,8'h3C,3'b000,1'b0}, // R1
    {2'd2,2'd1,8'h00,1'b0,6'h00,8'hB1,3'b000,1'b0}, // R1
    {2'd2,2'd2,8'h00,1'b0,6'h00,8'hA2,3'b000,1'b0}, // R1
    {2'd1,2'd3,8'h05,1'b0,6'h00,8'h00,3'b000,1'b0}, // R2
    {2'd1,2'd3,8'hC3,1'b1,6'h05,8'h00,3'b000,1'b0}, // R3
    {2'd1,2'd3,8'h07,1'b0,6'h05,8'h00,3'b000,1'b0}, // R2
    {2'd1,2'd1,8'h11,1'b0,6'h07,8'h00,3'b010,1'b0}, // R8
    {2'd1,2'd3,8'h9A,1'b1,6'h07,8'h00,3'b000,1'b0}, // R8 R3
    {2'd1,2'd3,8'h0C,1'b0,6'h07,8'h00,3'b000,1'b0}, // R2
    {2'd2,2'd3,8'h00,1'b0,6'h0C,8'h8C,3'b000,1'b0}, // R4
    {2'd1,2'd3,8'h04,1'b0,6'h0C,8'h00,3'b000,1'b0}, // R5
    {2'd2,2'd3,8'h00,1'b0,6'h04,8'h84,3'b000,1'b0}, // R5 R4
    {2'd1,2'd3,8'h00,1'b0,6'h04,8'h00,3'b000,1'b0}, // R2
    {2'd2,2'd3,8'h00,1'b0,6'h00,8'h00,3'b000,1'b0}, // R4 reg0
    {2'd1,2'd3,8'h00,1'b0,6'h00,8'h00,3'b000,1'b0}, // R2
    {2'd1,2'd3,8'h01,1'b0,6'h00,8'h00,3'b000,1'b1}, // R6 set
    {2'd1,2'd0,8'hFF,1'b0,6'h00,8'h00,3'b000,1'b1}, // R7 ignored
    {2'd1,2'd3,8'h03,1'b0,6'h00,8'h00,3'b000,1'b1}, // R7
    {2'd2,2'd3,8'h00,1'b0,6'h00,8'h01,3'b000,1'b1}, // R4 R6
    {2'd1,2'd3,8'h02,1'b0,6'h00,8'h00,3'b000,1'b0}, // R6 clear
    {2'd1,2'd3,8'h0A,1'b0,6'h00,8'h00,3'b000,1'b0}, // R2
    {2'd1,2'd3,8'h5B,1'b1,6'h0A,8'h00,3'b000,1'b0}, // R3
    {2'd1,2'd3,8'hFF,1'b0,6'h0A,8'h00,3'b000,1'b0}, // R2 truncation
    {2'd2,2'd3,8'h00,1'b0,6'h3F,8'hBF,3'b000,1'b0}  // R4
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    applied++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic access(input logic [1:0] op, input logic [1:0] a, input logic [7:0] d,
                        input logic e_wr, input logic [5:0] e_sel, input logic [7:0] e_rd,
                        input logic [2:0] e_pwe, input logic e_rst, input string req);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = (op == 2'd1); host_rd = (op == 2'd2);
    #2;
    check({req, " reg_wr"}, {7'b0, reg_wr}, {7'b0, e_wr});
    check({req, " reg_sel"}, {2'b0, reg_sel}, {2'b0, e_sel});
    check({req, " port_we"}, {5'b0, port_we}, {5'b0, e_pwe});
    if (op == 2'd2) check({req, " rdata"}, host_rdata, e_rd);
    if (op == 2'd2 && a == 2'd3) check({req, " reg_rd"}, {7'b0, reg_rd}, {7'b0, e_sel != 6'd0});
    if (e_wr) check({req, " reg_wdata"}, reg_wdata, d);
    @(posedge clk); #1;
    host_wr = 1'b0; host_rd = 1'b0;
    check({req, " dev_reset"}, {7'b0, dev_reset}, {7'b0, e_rst});
  endtask

  initial begin
    #200000;
    bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end

  initial begin
    #20;
    check("R6 reset dev_reset", {7'b0, dev_reset}, 8'h01);
    check("R6 reset reg_sel", {2'b0, reg_sel}, 8'h00);
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      logic [30:0] v;
      v = VEC[i];
      access(v[30:29], v[28:27], v[26:19], v[18], v[17:12], v[11:4], v[3:1], v[0], $sformatf("vec%0d", i));
    end
    // R9 recovery from the data phase with a nonzero pointer
    access(2'd1, 2'd3, 8'h09, 1'b0, 6'h3F, 8'h00, 3'b000, 1'b0, "R9 prep");
    access(2'd2, 2'd3, 8'h00, 1'b0, 6'h09, 8'h89, 3'b000, 1'b0, "R9 s1");
    access(2'd1, 2'd3, 8'h00, 1'b0, 6'h09, 8'h00, 3'b000, 1'b0, "R9 s2");
    access(2'd2, 2'd3, 8'h00, 1'b0, 6'h00, 8'h00, 3'b000, 1'b0, "R9 s3");
    access(2'd1, 2'd3, 8'h00, 1'b0, 6'h00, 8'h00, 3'b000, 1'b0, "R9 s4");
    access(2'd1, 2'd3, 8'h01, 1'b0, 6'h00, 8'h00, 3'b000, 1'b1, "R9 s5");
    access(2'd1, 2'd3, 8'h00, 1'b0, 6'h00, 8'h00, 3'b000, 1'b0, "R9 s6");
    access(2'd1, 2'd3, 8'h06, 1'b0, 6'h00, 8'h00, 3'b000, 1'b0, "R9 pointer phase");
    access(2'd1, 2'd3, 8'h44, 1'b1, 6'h06, 8'h00, 3'b000, 1'b0, "R9 data phase");
    // R9 recovery starting while reset is held
    access(2'd1, 2'd3, 8'h00, 1'b0, 6'h06, 8'h00, 3'b000, 1'b0, "R9 prep2");
    access(2'd1, 2'd3, 8'h01, 1'b0, 6'h00, 8'h00, 3'b000, 1'b1, "R9 prep3");
    access(2'd2, 2'd3, 8'h00, 1'b0, 6'h00, 8'h01, 3'b000, 1'b1, "R9 h1");
    access(2'd1, 2'd3, 8'h00, 1'b0, 6'h00, 8'h00, 3'b000, 1'b0, "R9 h2");
    access(2'd2, 2'd3, 8'h00, 1'b0, 6'h00, 8'h00, 3'b000, 1'b0, "R9 h3");
    access(2'd1, 2'd3, 8'h00, 1'b0, 6'h00, 8'h00, 3'b000, 1'b0, "R9 h4");
    access(2'd1, 2'd3, 8'h01, 1'b0, 6'h00, 8'h00, 3'b000, 1'b1, "R9 h5");
    access(2'd1, 2'd3, 8'h00, 1'b0, 6'h00, 8'h00, 3'b000, 1'b0, "R9 h6");
    access(2'd1, 2'd3, 8'h21, 1'b0, 6'h00, 8'h00, 3'b000, 1'b0, "R9 h pointer");
    access(2'd1, 2'd3, 8'h10, 1'b1, 6'h21, 8'h00, 3'b000, 1'b0, "R9 h data");
    // R6 mid-run reset
    access(2'd1, 2'd3, 8'h12, 1'b0, 6'h21, 8'h00, 3'b000, 1'b0, "R6 prep");
    @(negedge clk); rst_n = 1'b0; #2;
    check("R6 async dev_reset", {7'b0, dev_reset}, 8'h01);
    check("R6 async reg_sel", {2'b0, reg_sel}, 8'h00);
    @(negedge clk); rst_n = 1'b1;
    access(2'd1, 2'd0, 8'h01, 1'b0, 6'h00, 8'h00, 3'b000, 1'b1, "R7 port ignored after reset");
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end
endmodule